// File: doc/BRIEF.md
# Banked Byte Register File

This block holds the byte-wide registers of a monitoring device behind a single register read/write port, the kind of port a serial-bus target front end drives after it has decoded an address and a data byte. An 8-bit address window is mapped onto one of five banks by a bank pointer. Software changes the pointer by writing the bank-select register. Every other ordinary address in the window is plain byte storage belonging to the selected bank.

Four addresses do not follow the bank pointer. Three identification registers and the bank-select register itself answer the same way whichever bank is selected. This lets software identify the device and find its bank state without knowing which bank was selected last. Sixteen-bit quantities are held as two neighbouring bytes, the more significant one first. Read data is registered and appears one clock after the read strobe.

Top module: `brf_regfile`

## Requirements
- R1: After a synchronous reset, the selected bank is 0 and every general register in every bank reads 0x00. This includes registers written before that reset.
- R2: Writing a value from 0 to 4 to address 0xFF selects that bank. Reading 0xFF returns the bank number in bits 2:0, with bits 7:3 zero.
- R3: Writing a value of 5 or more to address 0xFF is ignored, and the previously selected bank stays in use.
- R4: From every bank, address 0x7A reads 0x50, 0x7B reads 0xC5 and 0x7C reads 0x51, whose upper nibble is 0x5.
- R5: Writes to 0x7A, 0x7B and 0x7C are ignored, and those addresses keep returning their fixed values.
- R6: A general address has separate storage in each bank. A write in one bank does not change the same address in another bank.
- R7: A 16-bit value written as its high byte at address N and its low byte at address N+1 reads back with the high byte at N and the low byte at N+1.
- R8: `rdata` is valid on the clock after `rd_en`, and `rd_valid` is high for exactly that cycle. `rdata` holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 8 | Register address within the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| rd_valid | output | 1 | High the cycle after a read strobe |

## Verification
The bench writes a bank number above the valid range. A design that range-checked wrongly would jump to an unbacked bank, or read back bits 7:3 set. It writes the same general address in two banks, which catches an index that ignores the bank pointer. It also writes to the ID addresses and then reads the IDs from all five banks: a design that banked the ID addresses or stored their writes would return wrong IDs. It resets again after writes to show that storage reads back zero, which a RAM without cleared valid flags would fail. It also checks that `rdata` stays put while no read is issued.

// File: rtl/brf_pkg.sv
package brf_pkg;
  // Source of the byte returned by a read, captured with the read strobe
  typedef enum logic [1:0] {
    SRC_STORE = 2'd0,
    SRC_CONST = 2'd1
  } rd_src_e;
endpackage

// File: rtl/brf_bank_sel.sv
module brf_bank_sel #(
  parameter int DW        = 8,
  parameter int NUM_BANKS = 5,
  parameter int BW        = $clog2(NUM_BANKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_we,
  input  logic [DW-1:0] sel_wdata,
  output logic [BW-1:0] bank
);
  // Out-of-range values leave the pointer unchanged
  logic in_range;
  assign in_range = (sel_wdata < DW'(NUM_BANKS));

  always_ff @(posedge clk) begin
    if (rst)
      bank <= '0;
    else if (sel_we && in_range)
      bank <= sel_wdata[BW-1:0];
  end
endmodule

// File: rtl/brf_fixed_decode.sv
module brf_fixed_decode #(
  parameter int          AW        = 8,
  parameter int          DW        = 8,
  parameter int          BW        = 3,
  parameter logic [7:0]  ID_BASE   = 8'h7A,
  parameter logic [7:0]  SEL_ADDR  = 8'hFF,
  parameter logic [7:0]  VENDOR_ID = 8'h50,
  parameter logic [7:0]  CHIP_ID   = 8'hC5,
  parameter logic [7:0]  DEV_ID    = 8'h51
) (
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] bank,
  output logic          is_fixed,
  output logic          is_sel,
  output logic [DW-1:0] fixed_val
);
  localparam logic [AW-1:0] A_VEN = AW'(ID_BASE);
  localparam logic [AW-1:0] A_CHP = AW'(ID_BASE + 8'd1);
  localparam logic [AW-1:0] A_DEV = AW'(ID_BASE + 8'd2);
  localparam logic [AW-1:0] A_SEL = AW'(SEL_ADDR);

  assign is_sel = (addr == A_SEL);

  always_comb begin
    is_fixed  = 1'b1;
    fixed_val = '0;
    unique case (addr)
      A_VEN:   fixed_val = DW'(VENDOR_ID);
      A_CHP:   fixed_val = DW'(CHIP_ID);
      A_DEV:   fixed_val = DW'(DEV_ID);
      A_SEL:   fixed_val = DW'(bank);
      default: is_fixed  = 1'b0;
    endcase
  end
endmodule

// File: rtl/brf_store.sv
module brf_store #(
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter int DEPTH = 1280,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q,
  output logic          q_vld
);
  // Data array has no reset so it maps to block RAM; a flag per entry
  // records whether it was written since reset.
  logic [DW-1:0] mem [DEPTH];
  logic [DEPTH-1:0] written;

  always_ff @(posedge clk) begin
    if (we)
      mem[idx] <= wdata;
    if (re)
      q <= mem[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written <= '0;
      q_vld   <= 1'b0;
    end else begin
      if (we)
        written[idx] <= 1'b1;
      if (re)
        q_vld <= written[idx];
    end
  end
endmodule

// File: rtl/brf_regfile.sv
module brf_regfile #(
  parameter int         AW        = 8,
  parameter int         DW        = 8,
  parameter int         NUM_BANKS = 5,
  parameter logic [7:0] ID_BASE   = 8'h7A,
  parameter logic [7:0] SEL_ADDR  = 8'hFF,
  parameter logic [7:0] VENDOR_ID = 8'h50,
  parameter logic [7:0] CHIP_ID   = 8'hC5,
  parameter logic [7:0] DEV_ID    = 8'h51
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rd_valid
);
  import brf_pkg::*;

  localparam int ENTRIES = 1 << AW;
  localparam int DEPTH   = NUM_BANKS * ENTRIES;
  localparam int IW      = $clog2(DEPTH);
  localparam int BW      = $clog2(NUM_BANKS);

  logic [BW-1:0] cur_bank;
  logic          is_fixed, is_sel;
  logic [DW-1:0] fixed_val;
  logic [IW-1:0] idx;
  logic [DW-1:0] st_q;
  logic          st_vld;
  rd_src_e       src_q;
  logic [DW-1:0] const_q;

  brf_fixed_decode #(
    .AW(AW), .DW(DW), .BW(BW), .ID_BASE(ID_BASE), .SEL_ADDR(SEL_ADDR),
    .VENDOR_ID(VENDOR_ID), .CHIP_ID(CHIP_ID), .DEV_ID(DEV_ID)
  ) u_dec (
    .addr(addr), .bank(cur_bank),
    .is_fixed(is_fixed), .is_sel(is_sel), .fixed_val(fixed_val)
  );

  brf_bank_sel #(.DW(DW), .NUM_BANKS(NUM_BANKS), .BW(BW)) u_bank (
    .clk(clk), .rst(rst),
    .sel_we(wr_en && is_sel), .sel_wdata(wdata), .bank(cur_bank)
  );

  assign idx = IW'(cur_bank) * IW'(ENTRIES) + IW'(addr);

  brf_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .IW(IW)) u_store (
    .clk(clk), .rst(rst),
    .we(wr_en && !is_fixed), .re(rd_en && !is_fixed),
    .idx(idx), .wdata(wdata), .q(st_q), .q_vld(st_vld)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q    <= SRC_CONST;
      const_q  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        src_q   <= is_fixed ? SRC_CONST : SRC_STORE;
        const_q <= fixed_val;
      end
    end
  end

  assign rdata = (src_q == SRC_STORE) ? (st_vld ? st_q : '0) : const_q;
endmodule

// File: rtl/brf_regfile_chk.sv
module brf_regfile_chk #(
  parameter int         AW        = 8,
  parameter int         DW        = 8,
  parameter int         NUM_BANKS = 5,
  parameter int         BW        = 3,
  parameter logic [7:0] ID_BASE   = 8'h7A,
  parameter logic [7:0] SEL_ADDR  = 8'hFF,
  parameter logic [7:0] VENDOR_ID = 8'h50,
  parameter logic [7:0] CHIP_ID   = 8'hC5
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          rd_valid,
  input logic [BW-1:0] bank
);
  // R8
  valid_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  // R8
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
  // R2
  sel_readback_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == AW'(SEL_ADDR) && !wr_en) |=> (rdata[DW-1:3] == '0));
  // R2
  bank_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    (32'(bank) < NUM_BANKS));
  // R3
  bad_bank_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(SEL_ADDR) && wdata >= DW'(NUM_BANKS)) |=> $stable(bank));
  // R4
  vendor_id_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == AW'(ID_BASE)) |=> (rdata == DW'(VENDOR_ID)));
  // R4
  chip_id_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == AW'(ID_BASE + 8'd1)) |=> (rdata == DW'(CHIP_ID)));
  // R4
  dev_id_nibble_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == AW'(ID_BASE + 8'd2)) |=> (rdata[7:4] == 4'h5));
endmodule

bind brf_regfile brf_regfile_chk #(
  .AW(AW), .DW(DW), .NUM_BANKS(NUM_BANKS), .BW(BW), .ID_BASE(ID_BASE),
  .SEL_ADDR(SEL_ADDR), .VENDOR_ID(VENDOR_ID), .CHIP_ID(CHIP_ID)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .bank(cur_bank)
);

// File: tb/brf_regfile_tb.sv
module brf_regfile_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rd_valid;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  brf_regfile u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid)
  );

  // op: 0 write, 1 read and compare; req is the requirement number
  typedef struct packed {
    logic       op;
    logic [7:0] a;
    logic [7:0] d;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'hFF, 8'h02, 8'd2},   // R2 select bank 2
    '{1'b1, 8'hFF, 8'h02, 8'd2},
    '{1'b0, 8'h10, 8'hAB, 8'd6},   // R6 store in bank 2
    '{1'b1, 8'h10, 8'hAB, 8'd6},
    '{1'b0, 8'hFF, 8'h07, 8'd3},   // R3 out of range, ignored
    '{1'b1, 8'hFF, 8'h02, 8'd3},
    '{1'b0, 8'hFF, 8'h00, 8'd2},
    '{1'b1, 8'h10, 8'h00, 8'd6},   // R6 bank 0 unaffected
    '{1'b0, 8'h10, 8'hCD, 8'd6},
    '{1'b1, 8'h10, 8'hCD, 8'd6},
    '{1'b0, 8'hFF, 8'h04, 8'd2},   // R2 top bank
    '{1'b1, 8'hFF, 8'h04, 8'd2},
    '{1'b1, 8'h10, 8'h00, 8'd6},
    '{1'b0, 8'h7A, 8'h00, 8'd5},   // R5 ID writes ignored
    '{1'b0, 8'h7C, 8'hFF, 8'd5},
    '{1'b1, 8'h7A, 8'h50, 8'd5},
    '{1'b1, 8'h7C, 8'h51, 8'd5},
    '{1'b0, 8'h20, 8'h12, 8'd7},   // R7 16-bit value 0x1234
    '{1'b0, 8'h21, 8'h34, 8'd7},
    '{1'b1, 8'h20, 8'h12, 8'd7},
    '{1'b1, 8'h21, 8'h34, 8'd7},
    '{1'b0, 8'hFF, 8'h05, 8'd3},   // R3 just above range
    '{1'b1, 8'hFF, 8'h04, 8'd3},
    '{1'b0, 8'hFF, 8'h02, 8'd6},
    '{1'b1, 8'h10, 8'hAB, 8'd6},
    '{1'b0, 8'hFF, 8'h80, 8'd3},   // R3 high bit set
    '{1'b1, 8'hFF, 8'h02, 8'd3},
    '{1'b1, 8'h7B, 8'hC5, 8'd4}    // R4
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input int req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input int req);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(rdata, exp, req);
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd_chk(8'hFF, 8'h00, 1);
    rd_chk(8'h10, 8'h00, 1);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].op) rd_chk(VECS[i].a, VECS[i].d, int'(VECS[i].req));
      else            wr(VECS[i].a, VECS[i].d);
    end

    // R8 timing: valid one cycle, data held afterwards
    @(negedge clk);
    rd_en = 1'b1; addr = 8'h7B;
    @(negedge clk);
    rd_en = 1'b0;
    check({7'd0, rd_valid}, 8'h01, 8);
    check(rdata, 8'hC5, 8);
    addr = 8'h7A;
    @(negedge clk);
    check({7'd0, rd_valid}, 8'h00, 8);
    check(rdata, 8'hC5, 8);

    // R4 IDs visible from every bank
    for (int b = 0; b < 5; b++) begin
      wr(8'hFF, 8'(b));
      rd_chk(8'h7A, 8'h50, 4);
      rd_chk(8'h7B, 8'hC5, 4);
      rd_chk(8'h7C, 8'h51, 4);
      rd_chk(8'hFF, 8'(b), 2);
    end

    // R1 reset after writes clears storage and bank
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    rd_chk(8'hFF, 8'h00, 1);
    rd_chk(8'h10, 8'h00, 1);
    wr(8'hFF, 8'h02);
    rd_chk(8'h10, 8'h00, 1);
    rd_chk(8'h20, 8'h00, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule